// File: doc/BRIEF.md
# Sensor Code to Millidegree Converter

This block turns one raw temperature sensor sample into a signed temperature in millidegrees Celsius. The conversion follows a calibrated linear law with four coefficients: an offset G, a gain H, a full-scale count called cal5, and a signed frequency correction J. The correction J is weighted by the sensor clock frequency F, given in Hz. The law is T = G + (H*n)/cal5 - H/2 + (J*F)/1000000. The result is then clamped to the range -40000 to 125000.

A sample is offered with a one-cycle valid strobe. When the block is idle it takes a snapshot of the code, the coefficients and the frequency, so they may change while a conversion runs. Both divisions run side by side in one shared iterative shift-subtract loop, one quotient bit per cycle. The result comes out a fixed number of cycles later with its own one-cycle strobe.

Two common coefficient sets are H=200000, G=60000, J=-100, cal5=4094 and H=249400, G=57400, J=0, cal5=4096.

Top module: `temp_code_converter`

## Requirements
- R1: The gain term is the 64-bit unsigned product H*n divided by cal5, truncated; for example, H=10, n=7, cal5=3 gives 23.
- R2: Only bits 15:0 of `in_raw` form the code n; bits 31:16 have no effect on the result.
- R3: The correction term is the signed 64-bit product J*F divided by 1000000, truncated toward zero; for example, J=-3 and F=999999 give -2, not -3.
- R4: The half-gain term is H shifted right by one bit as an unsigned value, so an odd H loses its low bit (H=3 subtracts 1).
- R5: A sum below -40000 is output as -40000, and -40000 itself passes unchanged.
- R6: A sum above 125000 is output as 125000, and 125000 itself passes unchanged.
- R7: When cal5 is zero, the output is 125000 and `out_err` is 1 in the same cycle as `out_valid`.
- R8: `out_valid` is a one-cycle pulse, seen 65 rising edges after the edge that accepts the input (PROD_W+1).
- R9: While `busy` is 1, `in_valid` is ignored: no extra result is produced and the current result is not disturbed.
- R10: After reset, `busy`, `out_valid` and `out_err` are 0 and `out_temp` is 0.
- R11: `out_err` is 0 for every result whose cal5 is nonzero.
- R12: `out_temp` and `out_err` hold their last values until the next `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; taken only when `busy` is 0 |
| in_raw | input | 32 | Raw sample word; low 16 bits are the code |
| coef_g | input | 32 | Offset G, unsigned, millidegrees |
| coef_h | input | 32 | Gain H, unsigned |
| coef_cal5 | input | 32 | Full-scale count divisor, unsigned |
| coef_j | input | 32 | Frequency correction J, signed |
| freq_hz | input | 32 | Sensor clock frequency in Hz, unsigned |
| busy | output | 1 | Conversion in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_temp | output | 32 | Signed clamped temperature, millidegrees |
| out_err | output | 1 | Set with a result when cal5 was zero |

## Verification
The assertions assume that `in_valid` and `rst_n` are never unknown after reset. They also assume that the 64-bit product width covers both products, so neither the quotients nor the sum can wrap. The stimulus keeps every coefficient within 32 bits and applies inputs between clock edges. It includes the extreme case J = -2^31 with F = 2^32-1, which sits at the very edge of that width assumption. The latency check in the checker counts edges from acceptance. It therefore relies on the block never accepting while busy, and the stimulus deliberately strobes in that window to test this.

// File: rtl/temp_code_converter.sv
module temp_code_converter #(
  parameter int RAW_W  = 32,
  parameter int CODE_W = 16,
  parameter int COEF_W = 32,
  parameter int FREQ_W = 32,
  parameter int OUT_W  = 32,
  parameter int PROD_W = 64,
  parameter int SCALE  = 1000000,
  parameter int T_MIN  = -40000,
  parameter int T_MAX  = 125000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [RAW_W-1:0]         in_raw,
  input  logic [COEF_W-1:0]        coef_g,
  input  logic [COEF_W-1:0]        coef_h,
  input  logic [COEF_W-1:0]        coef_cal5,
  input  logic signed [COEF_W-1:0] coef_j,
  input  logic [FREQ_W-1:0]        freq_hz,
  output logic                     busy,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_temp,
  output logic                     out_err
);

  localparam int CNT_W = $clog2(PROD_W);
  localparam int REM_W = COEF_W + 1;
  localparam int SUM_W = PROD_W + 2;
  localparam logic [COEF_W-1:0]       DSR_B = COEF_W'(SCALE);
  localparam logic signed [SUM_W-1:0] LO    = SUM_W'(T_MIN);
  localparam logic signed [SUM_W-1:0] HI    = SUM_W'(T_MAX);

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_SUM} state_t;
  state_t state;

  logic [PROD_W-1:0] dvd_a, dvd_b;
  logic [COEF_W-1:0] rem_a, rem_b, dsr_a, g_q, hh_q;
  logic [CNT_W-1:0]  cnt;
  logic              neg_b, zero_div;

  wire accept = in_valid && (state == ST_IDLE);
  assign busy = (state != ST_IDLE);

  wire [CODE_W-1:0] code  = in_raw[CODE_W-1:0];
  wire [COEF_W-1:0] j_mag = coef_j[COEF_W-1] ? (~coef_j + 1'b1) : coef_j;
  wire [PROD_W-1:0] prod_a = PROD_W'(coef_h) * PROD_W'(code);
  wire [PROD_W-1:0] prod_b = PROD_W'(j_mag) * PROD_W'(freq_hz);

  logic [REM_W-1:0]  tr_a, tr_b, df_a, df_b;
  logic              ge_a, ge_b;
  logic [COEF_W-1:0] rem_a_n, rem_b_n;

  always_comb begin
    tr_a    = {rem_a, dvd_a[PROD_W-1]};
    tr_b    = {rem_b, dvd_b[PROD_W-1]};
    df_a    = tr_a - {1'b0, dsr_a};
    df_b    = tr_b - {1'b0, DSR_B};
    ge_a    = tr_a >= {1'b0, dsr_a};
    ge_b    = tr_b >= {1'b0, DSR_B};
    rem_a_n = ge_a ? df_a[COEF_W-1:0] : tr_a[COEF_W-1:0];
    rem_b_n = ge_b ? df_b[COEF_W-1:0] : tr_b[COEF_W-1:0];
  end

  logic signed [SUM_W-1:0] s_qb, total, clamped;

  always_comb begin
    s_qb  = $signed({2'b00, dvd_b});
    if (neg_b) s_qb = -s_qb;
    total = $signed(SUM_W'(g_q)) + $signed({2'b00, dvd_a})
          - $signed(SUM_W'(hh_q)) + s_qb;
    if (zero_div)       clamped = HI;
    else if (total < LO) clamped = LO;
    else if (total > HI) clamped = HI;
    else                 clamped = total;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dvd_a     <= '0;
      dvd_b     <= '0;
      rem_a     <= '0;
      rem_b     <= '0;
      dsr_a     <= '0;
      g_q       <= '0;
      hh_q      <= '0;
      cnt       <= '0;
      neg_b     <= 1'b0;
      zero_div  <= 1'b0;
      out_valid <= 1'b0;
      out_temp  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          dvd_a    <= prod_a;
          dvd_b    <= prod_b;
          rem_a    <= '0;
          rem_b    <= '0;
          dsr_a    <= coef_cal5;
          g_q      <= coef_g;
          hh_q     <= coef_h >> 1;
          neg_b    <= coef_j[COEF_W-1];
          zero_div <= (coef_cal5 == '0);
          cnt      <= '0;
          state    <= ST_DIV;
        end
        ST_DIV: begin
          dvd_a <= {dvd_a[PROD_W-2:0], ge_a};
          dvd_b <= {dvd_b[PROD_W-2:0], ge_b};
          rem_a <= rem_a_n;
          rem_b <= rem_b_n;
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(PROD_W - 1)) state <= ST_SUM;
        end
        ST_SUM: begin
          out_temp  <= clamped[OUT_W-1:0];
          out_err   <= zero_div;
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/temp_code_converter_chk.sv
module temp_code_converter_chk #(
  parameter int OUT_W  = 32,
  parameter int PROD_W = 64,
  parameter int T_MIN  = -40000,
  parameter int T_MAX  = 125000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    busy,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_temp,
  input logic                    out_err
);

  localparam int LC_W = $clog2(PROD_W + 4) + 1;
  logic [LC_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (in_valid && !busy) lat_cnt <= LC_W'(1);
    else if (busy)             lat_cnt <= lat_cnt + 1'b1;
    else                       lat_cnt <= '0;
  end

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lat_cnt == LC_W'(PROD_W + 2));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_temp >= T_MIN);

  assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_temp <= T_MAX);

  assert_err_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_temp == T_MAX);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_temp) && $stable(out_err)));

endmodule

bind temp_code_converter temp_code_converter_chk #(
  .OUT_W(OUT_W), .PROD_W(PROD_W), .T_MIN(T_MIN), .T_MAX(T_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .out_temp(out_temp), .out_err(out_err)
);

// File: tb/temp_code_converter_tb.sv
module temp_code_converter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int EXP_LAT = 65;

  // fields: raw, g, h, cal5, j, f, expected
  localparam logic [223:0] VECS [NV] = '{
    {32'd2047,      32'd60000,  32'd200000, 32'd4094, 32'hFFFFFF9C, 32'd100000000, 32'd50000},    // R1 preset A
    {32'd2048,      32'd57400,  32'd249400, 32'd4096, 32'd0,         32'd50000000,  32'd57400},    // R1 preset B
    {32'hABCD0800,  32'd57400,  32'd249400, 32'd4096, 32'd0,         32'd50000000,  32'd57400},    // R2
    {32'd5,         32'd1000,   32'd0,      32'd1,    32'hFFFFFFFD,  32'd999999,    32'd998},      // R3 neg
    {32'd5,         32'd1000,   32'd0,      32'd1,    32'd7,         32'd333333,    32'd1002},     // R3 pos
    {32'd0,         32'd500,    32'd3,      32'd1,    32'd0,         32'd0,         32'd499},      // R4
    {32'd7,         32'd0,      32'd10,     32'd3,    32'd0,         32'd0,         32'd18},       // R1 trunc
    {32'd0,         32'd0,      32'd200000, 32'd4094, 32'd0,         32'd0,         32'hFFFF63C0}, // R5
    {32'd0,         32'd0,      32'd80000,  32'd1,    32'd0,         32'd0,         32'hFFFF63C0}, // R5 edge
    {32'd0,         32'd200000, 32'd0,      32'd1,    32'd0,         32'd0,         32'd125000},   // R6
    {32'd0,         32'd125000, 32'd0,      32'd1,    32'd0,         32'd0,         32'd125000},   // R6 edge
    {32'd5,         32'd0,      32'd100,    32'd0,    32'd0,         32'd0,         32'd125000},   // R7
    {32'd0,         32'd0,      32'd0,      32'd1,    32'h80000000,  32'hFFFFFFFF,  32'hFFFF63C0}  // R3 R5 wide
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_raw = '0, coef_g = '0, coef_h = '0, coef_cal5 = '0, freq_hz = '0;
  logic signed [31:0] coef_j = '0;
  logic busy, out_valid, out_err;
  logic signed [31:0] out_temp;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_code_converter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .coef_g(coef_g), .coef_h(coef_h), .coef_cal5(coef_cal5), .coef_j(coef_j),
    .freq_hz(freq_hz), .busy(busy), .out_valid(out_valid),
    .out_temp(out_temp), .out_err(out_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [223:0] v);
    in_raw    = v[223:192];
    coef_g    = v[191:160];
    coef_h    = v[159:128];
    coef_cal5 = v[127:96];
    coef_j    = v[95:64];
    freq_hz   = v[63:32];
  endtask

  task automatic wait_result(output int lat);
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    @(negedge clk);
    @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 out_valid", out_valid, 0);
    check("R10 out_temp", out_temp, 0);
    check("R10 out_err", out_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      wait_result(lat);
      check($sformatf("R8 latency vec %0d", i), lat, EXP_LAT);
      check($sformatf("R1-law vec %0d (R1 R3 R4 R5 R6)", i), out_temp,
            $signed(VECS[i][31:0]));
      if (VECS[i][127:96] == 32'd0)
        check($sformatf("R7 err vec %0d", i), out_err, 1);
      else
        check($sformatf("R11 err vec %0d", i), out_err, 0);
      @(negedge clk);
      check($sformatf("R8 pulse vec %0d", i), out_valid, 0);
    end

    // R9: strobe while busy is ignored
    load(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    load(VECS[9]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 11;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check("R9 latency unchanged", lat, EXP_LAT);
    check("R9 result from first sample", out_temp, 50000);
    begin
      int extra = 0;
      for (int k = 0; k < 120; k++) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      check("R9 no second result", extra, 0);
    end

    // R12: output held between results
    check("R12 held temp", out_temp, 50000);
    check("R12 held err", out_err, 0);
    load(VECS[11]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (30) @(negedge clk);
    check("R12 held mid-run", out_temp, 50000);
    wait_result(lat);
    check("R7 flagged", out_err, 1);
    check("R7 value", out_temp, 125000);
    repeat (5) @(negedge clk);
    check("R12 err held", out_err, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule